// File: doc/BRIEF.md
# USB Data Packet Receive Checker

This block sits behind a byte-wide USB receive interface (received byte, byte-valid strobe, packet-active level, receive-error flag). It treats each period in which the active level is high as one packet. The first byte of a packet is taken as the packet identifier and checked for its complement nibble. The bytes between the identifier and the last two bytes are the payload. They are forwarded one per cycle on a byte stream output and are folded into a CRC16. The last two bytes are held back and compared with the computed checksum.

A short, fixed-depth holding line keeps the two most recent bytes, so the checksum bytes never reach the payload stream, whatever the packet length. When the active level falls, the block produces a one-cycle completion pulse and a status set: the identifier, the payload length, an identifier error, a checksum error, whether the identifier matched the expected data toggle, and an overall good flag. The expected toggle alternates after each good packet that matched it, and a control input returns it to the first toggle value, for example after a control setup stage.

Top module: `usb_data_rx_check`

## Requirements
- R1: A byte is taken only in a cycle where `rx_valid` and `rx_active` are both high; bytes present in any other cycle have no effect on the payload stream, the length or the checksum.
- R2: A packet ends at the first rising clock edge that samples `rx_active` low after it was high; `done` is high for exactly the cycle after that edge, and all status outputs update then and hold their values until the next `done`.
- R3: The first byte of a packet is the identifier: bits [3:0] are reported on `st_pid`, and `st_pid_err` is set unless bits [7:4] equal the bitwise complement of bits [3:0] (a packet with no byte also sets it).
- R4: The checksum is CRC16 with polynomial x^16 + x^15 + x^2 + 1, bits taken least significant first, register preset to 0xFFFF and updated over payload bytes only; the last two bytes must equal the inverted register, low byte first, else `st_crc_err` is set; a packet of fewer than three bytes also sets `st_crc_err`.
- R5: Payload bytes appear on `out_byte` in arrival order, each with one cycle of `out_valid`; the identifier and the two final bytes are never forwarded, and `out_valid` is never high in the `done` cycle.
- R6: `st_len` is the number of bytes taken in the packet minus three, or zero when fewer than three bytes were taken.
- R7: A packet of identifier plus checksum only, with the checksum of an empty payload (preset register, inverted), is reported with length zero and no checksum error.
- R8: If `rx_err` is high in any cycle while `rx_active` is high, `st_good` is low for that packet.
- R9: `st_good` is high exactly when neither identifier error, checksum error nor receive error occurred.
- R10: DATA0 is identifier value 0x3 and DATA1 is 0xB; `st_tog_ok` is high when the identifier has no error and equals the expected toggle; the expectation flips only after a packet with `st_good` and `st_tog_ok` both high.
- R11: A cycle with `tog_clear` high sets the expectation to DATA0, taking priority over a flip in the same cycle.
- R12: After reset `out_valid`, `done` and all status outputs are zero and the expectation is DATA0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_byte | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte is valid this cycle |
| rx_active | input | 1 | High for the duration of a packet |
| rx_err | input | 1 | Receive error flag |
| tog_clear | input | 1 | Return expected toggle to DATA0 |
| out_byte | output | 8 | Forwarded payload byte |
| out_valid | output | 1 | `out_byte` holds a payload byte |
| done | output | 1 | One-cycle end-of-packet pulse |
| st_pid | output | 4 | Identifier value (low nibble of first byte) |
| st_len | output | LEN_W | Payload length in bytes |
| st_pid_err | output | 1 | Identifier complement check failed |
| st_crc_err | output | 1 | Checksum mismatch or packet too short |
| st_tog_ok | output | 1 | Identifier equals the expected toggle |
| st_good | output | 1 | Packet free of all errors |

## Verification
The hardest state to reach is an expected toggle that must survive a rejected packet: a packet whose identifier matches the expectation but whose checksum is wrong must leave the expectation unchanged, and that is only visible through the `st_tog_ok` of the following packet. The stimulus therefore runs chained sequences (good DATA0, good DATA1, a repeated DATA1, a corrupted-checksum DATA1 followed by a clean DATA1, a receive-error packet, then a clear pulse) while a bench model of the toggle predicts each outcome. Payload bytes go into a scoreboard queue before each packet, so any forwarded checksum byte or missing payload byte shows up as a mismatch or a leftover entry.

// File: rtl/usb_rx_pkg.sv
`timescale 1ns/1ps
package usb_rx_pkg;

    localparam int          BYTE_W     = 8;
    localparam int          CRC_BYTES  = 2;
    localparam int          OVERHEAD   = 1 + CRC_BYTES;
    localparam logic [15:0] CRC_INIT   = 16'hFFFF;
    localparam logic [15:0] CRC_POLY_R = 16'hA001;   // x^16+x^15+x^2+1, reflected
    localparam logic [3:0]  PID_DATA0  = 4'h3;
    localparam logic [3:0]  PID_DATA1  = 4'hB;

    typedef struct packed {
        logic [3:0] pid;
        logic       pid_err;
        logic       crc_err;
        logic       tog_ok;
        logic       good;
    } rx_status_t;

    // One byte of the checksum, least significant bit first.
    function automatic logic [15:0] crc16_step(input logic [15:0] c,
                                               input logic [BYTE_W-1:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < BYTE_W; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_R;
            else             r = r >> 1;
        end
        return r;
    endfunction

    function automatic logic pid_well_formed(input logic [BYTE_W-1:0] b);
        return b[7:4] == ~b[3:0];
    endfunction

endpackage

// File: rtl/usb_rx_tail_strip.sv
`timescale 1ns/1ps
// Holds the DEPTH most recent bytes; a byte leaves only when pushed out by a newer one.
module usb_rx_tail_strip #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      clr,
    input  logic                      push,
    input  logic [W-1:0]              din,
    output logic [DEPTH-1:0][W-1:0]   tail,
    output logic                      full,
    output logic                      fwd_valid,
    output logic [W-1:0]              fwd_byte
);
    localparam int FILL_W = $clog2(DEPTH + 1);

    logic [DEPTH-1:0][W-1:0] stage;
    logic [FILL_W-1:0]       fill;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            stage <= '0;
            fill  <= '0;
        end else if (push) begin
            stage[0] <= din;
            for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
            if (fill != FILL_W'(DEPTH)) fill <= fill + 1'b1;
        end
    end

    assign full      = (fill == FILL_W'(DEPTH));
    assign fwd_valid = push && full;
    assign fwd_byte  = stage[DEPTH-1];
    assign tail      = stage;
endmodule

// File: rtl/usb_rx_crc16.sv
`timescale 1ns/1ps
module usb_rx_crc16
    import usb_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              en,
    input  logic [BYTE_W-1:0] din,
    output logic [15:0]       crc
);
    always_ff @(posedge clk) begin
        if (rst || clr) crc <= CRC_INIT;
        else if (en)    crc <= crc16_step(crc, din);
    end
endmodule

// File: rtl/usb_rx_toggle.sv
`timescale 1ns/1ps
module usb_rx_toggle
    import usb_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       upd,
    input  logic [3:0] pid,
    input  logic       pkt_good,
    output logic       match
);
    logic expect_one;

    assign match = (pid == (expect_one ? PID_DATA1 : PID_DATA0));

    always_ff @(posedge clk) begin
        if (rst || clear)                 expect_one <= 1'b0;
        else if (upd && pkt_good && match) expect_one <= ~expect_one;
    end
endmodule

// File: rtl/usb_data_rx_check.sv
`timescale 1ns/1ps
module usb_data_rx_check
    import usb_rx_pkg::*;
#(
    parameter  int MAX_PAYLOAD = 1023,
    localparam int LEN_W       = $clog2(MAX_PAYLOAD + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        rx_byte,
    input  logic              rx_valid,
    input  logic              rx_active,
    input  logic              rx_err,
    input  logic              tog_clear,
    output logic [7:0]        out_byte,
    output logic              out_valid,
    output logic              done,
    output logic [3:0]        st_pid,
    output logic [LEN_W-1:0]  st_len,
    output logic              st_pid_err,
    output logic              st_crc_err,
    output logic              st_tog_ok,
    output logic              st_good
);
    localparam int CNT_W = $clog2(MAX_PAYLOAD + OVERHEAD + 1);

    logic                         act_q;
    logic [CNT_W-1:0]             cnt;
    logic [BYTE_W-1:0]            pid_q;
    logic                         err_seen;
    rx_status_t                   stat_q;
    logic [LEN_W-1:0]             len_q;

    logic                         cap, pkt_end, data_cap;
    logic [CRC_BYTES-1:0][BYTE_W-1:0] tail;
    logic                         tail_full, fwd_valid;
    logic [BYTE_W-1:0]            fwd_byte;
    logic [15:0]                  crc_val;
    logic                         tog_match;

    logic                         short_pkt, crc_match, pid_bad, crc_bad, good_now;
    logic [LEN_W-1:0]             len_now;
    rx_status_t                   stat_now;

    assign cap      = rx_valid && rx_active;
    assign pkt_end  = act_q && !rx_active;
    assign data_cap = cap && (cnt != '0);

    usb_rx_tail_strip #(.W(BYTE_W), .DEPTH(CRC_BYTES)) i_tail (
        .clk      (clk),
        .rst      (rst),
        .clr      (pkt_end),
        .push     (data_cap),
        .din      (rx_byte),
        .tail     (tail),
        .full     (tail_full),
        .fwd_valid(fwd_valid),
        .fwd_byte (fwd_byte)
    );

    usb_rx_crc16 i_crc (
        .clk(clk),
        .rst(rst),
        .clr(pkt_end),
        .en (fwd_valid),
        .din(fwd_byte),
        .crc(crc_val)
    );

    usb_rx_toggle i_tog (
        .clk     (clk),
        .rst     (rst),
        .clear   (tog_clear),
        .upd     (pkt_end),
        .pid     (pid_q[3:0]),
        .pkt_good(good_now),
        .match   (tog_match)
    );

    // End-of-packet evaluation: tail[0] is the last byte (checksum high half).
    always_comb begin
        short_pkt = (cnt < CNT_W'(OVERHEAD));
        crc_match = tail_full && (tail[0] == ~crc_val[15:8])
                              && (tail[1] == ~crc_val[7:0]);
        pid_bad   = (cnt == '0) || !pid_well_formed(pid_q);
        crc_bad   = short_pkt || !crc_match;
        good_now  = !pid_bad && !crc_bad && !err_seen;
        len_now   = short_pkt ? '0 : LEN_W'(cnt - CNT_W'(OVERHEAD));
        stat_now.pid     = pid_q[3:0];
        stat_now.pid_err = pid_bad;
        stat_now.crc_err = crc_bad;
        stat_now.tog_ok  = tog_match && !pid_bad;
        stat_now.good    = good_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q     <= 1'b0;
            cnt       <= '0;
            pid_q     <= '0;
            err_seen  <= 1'b0;
            stat_q    <= '0;
            len_q     <= '0;
            done      <= 1'b0;
            out_valid <= 1'b0;
            out_byte  <= '0;
        end else begin
            act_q     <= rx_active;
            done      <= pkt_end;
            out_valid <= fwd_valid;
            if (fwd_valid) out_byte <= fwd_byte;
            if (pkt_end) begin
                stat_q   <= stat_now;
                len_q    <= len_now;
                cnt      <= '0;
                pid_q    <= '0;
                err_seen <= 1'b0;
            end else begin
                if (cap && cnt != '1) cnt <= cnt + 1'b1;
                if (cap && cnt == '0) pid_q <= rx_byte;
                if (rx_active && rx_err) err_seen <= 1'b1;
            end
        end
    end

    assign st_pid     = stat_q.pid;
    assign st_len     = len_q;
    assign st_pid_err = stat_q.pid_err;
    assign st_crc_err = stat_q.crc_err;
    assign st_tog_ok  = stat_q.tog_ok;
    assign st_good    = stat_q.good;
endmodule

// File: rtl/usb_rx_check_sva.sv
`timescale 1ns/1ps
module usb_rx_check_sva #(
    parameter int LEN_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_valid,
    input logic             rx_active,
    input logic             out_valid,
    input logic             done,
    input logic [LEN_W-1:0] st_len,
    input logic             st_pid_err,
    input logic             st_crc_err,
    input logic             st_tog_ok,
    input logic             st_good
);
    p_fwd_needs_capture_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(rx_valid && rx_active));

    p_done_after_fall_r2: assert property (@(posedge clk) disable iff (rst)
        done |-> !$past(rx_active));

    p_done_single_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_status_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(st_len) && $stable(st_good) && $stable(st_crc_err)));

    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        !rx_active |=> !out_valid);

    p_done_no_out_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> !out_valid);

    p_good_clean_r9: assert property (@(posedge clk) disable iff (rst)
        st_good |-> (!st_pid_err && !st_crc_err));

    p_tog_needs_pid_r10: assert property (@(posedge clk) disable iff (rst)
        st_tog_ok |-> !st_pid_err);
endmodule

bind usb_data_rx_check usb_rx_check_sva #(.LEN_W(LEN_W)) i_sva (
    .clk       (clk),
    .rst       (rst),
    .rx_valid  (rx_valid),
    .rx_active (rx_active),
    .out_valid (out_valid),
    .done      (done),
    .st_len    (st_len),
    .st_pid_err(st_pid_err),
    .st_crc_err(st_crc_err),
    .st_tog_ok (st_tog_ok),
    .st_good   (st_good)
);

// File: tb/test_usb_data_rx_check.sv
`timescale 1ns/1ps
module test_usb_data_rx_check;
    localparam int LW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    rx_byte = '0;
    logic          rx_valid = 1'b0, rx_active = 1'b0, rx_err = 1'b0, tog_clear = 1'b0;
    logic [7:0]    out_byte;
    logic          out_valid, done, st_pid_err, st_crc_err, st_tog_ok, st_good;
    logic [3:0]    st_pid;
    logic [LW-1:0] st_len;

    int total = 0, bad = 0, cycles = 0;
    bit finished = 0;
    bit exp_one = 0;
    logic [7:0] exp_q[$];
    logic [7:0] pkt_q[$];

    always #2 clk = ~clk;

    usb_data_rx_check i_usb_data_rx_check (
        .clk(clk), .rst(rst), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .rx_active(rx_active), .rx_err(rx_err), .tog_clear(tog_clear),
        .out_byte(out_byte), .out_valid(out_valid), .done(done),
        .st_pid(st_pid), .st_len(st_len), .st_pid_err(st_pid_err),
        .st_crc_err(st_crc_err), .st_tog_ok(st_tog_ok), .st_good(st_good)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
            summary();
        end
    end

    // Scoreboard monitor: every forwarded byte must be the next expected payload byte (R5).
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) chk(0, "R5", "unexpected out byte", out_byte, -1);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(out_byte === e, "R5", "payload byte", out_byte, e);
            end
        end
    end

    // Checksum reference: MSB-first form on bit-reversed bytes.
    function automatic logic [7:0] rev8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    function automatic logic [15:0] crc_ref(input logic [15:0] r, input logic [7:0] b);
        logic [7:0] m;
        logic [15:0] s;
        logic fb;
        m = rev8(b);
        s = r;
        for (int i = 7; i >= 0; i--) begin
            fb = s[15] ^ m[i];
            s = s << 1;
            if (fb) s = s ^ 16'h8005;
        end
        return s;
    endfunction

    task automatic build(input logic [7:0] pidb, input int n, input int seed, input bit bad_crc);
        logic [15:0] r, tx;
        logic [7:0]  b, lo;
        pkt_q.delete();
        pkt_q.push_back(pidb);
        r = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            b = 8'(seed * 37 + i * 13 + (i >> 2) * 91 + 5);
            pkt_q.push_back(b);
            exp_q.push_back(b);
            r = crc_ref(r, b);
        end
        tx = ~{rev8(r[7:0]), rev8(r[15:8])};
        lo = tx[7:0];
        if (bad_crc) lo = lo ^ 8'h01;
        pkt_q.push_back(lo);
        pkt_q.push_back(tx[15:8]);
    endtask

    // Drives pkt_q, then checks status against the requirement model.
    task automatic run(input string req, input bit bad_crc, input int gap, input int err_at);
        int nb, exp_len;
        bit pid_bad, ce, tok, good;
        logic [7:0] pidb;
        logic [LW-1:0] len_hold;
        pidb = pkt_q[0];
        nb = pkt_q.size();
        @(negedge clk);
        rx_active = 1; rx_valid = 0;
        for (int i = 0; i < nb; i++) begin
            if (gap > 0) begin
                @(negedge clk);
                rx_valid = 0; rx_byte = 8'hEE;   // ignored junk (R1)
            end
            @(negedge clk);
            rx_valid = 1; rx_byte = pkt_q[i]; rx_err = (i == err_at);
        end
        @(negedge clk);
        rx_valid = 0; rx_err = 0;
        @(negedge clk);
        rx_active = 0;
        @(negedge clk);
        pid_bad = (pidb[7:4] != ~pidb[3:0]);
        ce      = (nb < 3) || bad_crc;
        exp_len = (nb < 3) ? 0 : nb - 3;
        tok     = !pid_bad && (pidb[3:0] == (exp_one ? 4'hB : 4'h3));
        good    = !pid_bad && !ce && (err_at < 0);
        if (good && tok) exp_one = ~exp_one;
        chk(done === 1'b1, {req, " R2"}, "done pulse", done, 1);
        chk(st_pid === pidb[3:0], {req, " R3"}, "pid", st_pid, pidb[3:0]);
        chk(st_pid_err === pid_bad, {req, " R3"}, "pid_err", st_pid_err, pid_bad);
        chk(st_crc_err === ce, {req, " R4"}, "crc_err", st_crc_err, ce);
        chk(st_len === LW'(exp_len), {req, " R6"}, "len", st_len, exp_len);
        chk(st_tog_ok === tok, {req, " R10"}, "tog_ok", st_tog_ok, tok);
        chk(st_good === good, {req, " R9"}, "good", st_good, good);
        chk(exp_q.size() == 0, {req, " R5"}, "payload left over", exp_q.size(), 0);
        len_hold = st_len;
        @(negedge clk);
        chk(done === 1'b0, {req, " R2"}, "done single", done, 0);
        chk(st_len === len_hold, {req, " R2"}, "status hold", st_len, len_hold);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R12: reset state
        chk(out_valid === 0 && done === 0, "R12", "out_valid|done", {out_valid, done}, 0);
        chk(st_good === 0 && st_tog_ok === 0 && st_len === 0, "R12", "status",
            {st_good, st_tog_ok}, 0);

        build(8'hC3, 5, 1, 0);  run("R12 first DATA0", 0, 0, -1);
        build(8'h4B, 3, 2, 0);  run("R1 gapped DATA1", 0, 1, -1);
        build(8'h4B, 4, 3, 0);  run("R10 repeated DATA1", 0, 0, -1);
        build(8'hC3, 0, 4, 0);  run("R7 zero length", 0, 0, -1);
        build(8'h4B, 6, 5, 1);  run("R4 bad crc", 1, 0, -1);
        build(8'h4B, 2, 6, 0);  run("R10 no flip after bad", 0, 0, -1);
        build(8'h33, 3, 7, 0);  run("R3 bad pid", 0, 0, -1);
        build(8'hC3, 4, 8, 0);  run("R8 rx error", 0, 0, 3);
        build(8'hC3, 1, 9, 0);  run("R10 DATA0 flip", 0, 0, -1);
        // R11: clear expectation back to DATA0
        @(negedge clk); tog_clear = 1;
        @(negedge clk); tog_clear = 0;
        exp_one = 0;
        build(8'hC3, 2, 10, 0); run("R11 after clear", 0, 1, -1);
        // R4/R6: two-byte packet is too short
        pkt_q.delete(); pkt_q.push_back(8'h4B); pkt_q.push_back(8'h11);
        run("R4 short", 1, 0, -1);
        build(8'h4B, 64, 11, 0); run("R5 long", 0, 0, -1);
        // R1: bytes with rx_active low are ignored
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            rx_valid = 1; rx_byte = 8'(i + 8'h60);
            @(negedge clk);
            chk(done === 0 && out_valid === 0, "R1", "idle byte effect", {done, out_valid}, 0);
        end
        rx_valid = 0;
        build(8'hC3, 3, 12, 0); run("R1 after idle", 0, 0, -1);
        repeat (4) @(negedge clk);
        summary();
    end
endmodule